// File: doc/BRIEF.md
# Dual-FIFO Interprocessor Mailbox

The block carries 96-bit messages between an application processor and an I/O co-processor through two independent queues. The forward queue always carries traffic from the application side to the I/O side, and the return queue always carries traffic back. Both agents share one register map on a simple register bus made of an address, a write strobe with write data, and a read strobe with registered read data.

A sender first writes the upper 64 bits of a message into a staging word, then writes the lower 32 bits. The message enters the queue only on that second write. A receiver can look at the head entry's upper word without removing it. It then reads the second receive word, which returns the 32-bit payload together with the queue's occupancy and pointers, and removes the entry. Four interrupt conditions latch, so a condition that occurred once is remembered until software acknowledges it. Each condition is gated by its own enable bit and feeds one of two level-sensitive interrupt lines, one line per side.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues are empty, so their control words read bit 17 = 1, bit 16 = 0 and bit 18 = 0. The enable register at 0x48 reads 0 and both interrupt lines are low.
- R2: A write to the staging word (forward queue 0x60, return queue 0x90) does not change the queue. A write to the commit word (0x68, 0x98) pushes {staged 64 bits, write data bits 31:0} as one entry.
- R3: Entries leave in the order they were pushed. A read of the peek word (0x70, 0xA0) returns bits 95:32 of the head entry and leaves the queue unchanged.
- R4: A read of the pop word (0x78, 0xA8) on a non-empty queue removes the head entry. It returns bits 56:52 = entries held, bits 51:48 = free entries saturated at 15, bits 47:44 = read pointer, bits 43:40 = write pointer and bits 31:0 = the payload, all taken before the removal. Every other bit reads 0.
- R5: A queue holds 16 entries, and its control word (0x50 forward, 0x80 return) shows full in bit 16. A commit while full is dropped and sets sticky bit 18. Writing 1 to bit 18 of the control word clears it.
- R6: A peek or pop read of an empty queue returns 0 and moves no pointer.
- R7: Status bits (read at 0x4C) are: bit 0 = forward queue empty, bit 1 = forward queue not empty, bit 2 = return queue empty, bit 3 = return queue not empty. A bit sets on the cycle after its condition holds and stays set until it is acknowledged.
- R8: Writing 1 to a bit at 0x4C clears that status bit on the next cycle. If the condition still holds, the bit sets again one cycle later.
- R9: `irq_app` is the OR of enabled status bits 0 and 3. `irq_iop` is the OR of enabled status bits 1 and 2. The enables are written at 0x48, bits 3:0.
- R10: Read data appears on the cycle after the read strobe and holds until the next read. Traffic on one queue never changes the other queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rd | input | 1 | Read strobe; pop reads have a side effect |
| reg_rdata | output | 64 | Registered read data |
| irq_app | output | 1 | Level interrupt toward the application processor |
| irq_iop | output | 1 | Level interrupt toward the I/O processor |

## Verification
The assertions check, on every cycle, properties that relate one cycle to the next:
- a staging write never changes occupancy, and a commit to a non-full queue raises occupancy by one;
- a commit to a full queue sets the overflow flag;
- a pop read of an empty queue leaves occupancy alone;
- an empty queue latches its status bit;
- an acknowledge clears its status bit;
- an interrupt line stays low while its enables are clear.

Only the bench scenarios can show the properties that span many cycles: first-in first-out ordering across many entries, the exact status-word fields and pointer wrap, the one-cycle drop and return of a status bit acknowledged while its condition still holds, and the overflow clear. The bench's behavioural model is compared against the read data and both interrupt lines every cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 64;
  localparam int HI_W    = 64;
  localparam int LO_W    = 32;
  localparam int MSG_W   = HI_W + LO_W;
  localparam int NFIFO   = 2;
  localparam int NIRQ    = 4;

  // shared registers
  localparam logic [ADDR_W-1:0] A_IRQ_EN  = 8'h48;
  localparam logic [ADDR_W-1:0] A_IRQ_ACK = 8'h4C;

  // per-queue offsets from the queue's control word
  localparam logic [ADDR_W-1:0] OFS_STAGE  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_COMMIT = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_PEEK   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_POP    = 8'h28;

  // control word flags
  localparam int BIT_FULL  = 16;
  localparam int BIT_EMPTY = 17;
  localparam int BIT_OVF   = 18;

  // status bit indices: queue f empty = 2f, not empty = 2f+1
  localparam int ST_HELD_W = 5;
  localparam int ST_PTR_W  = 4;

  typedef struct packed {
    logic [6:0]           rsv_hi;
    logic [ST_HELD_W-1:0] held;
    logic [ST_PTR_W-1:0]  room;
    logic [ST_PTR_W-1:0]  rd_ptr;
    logic [ST_PTR_W-1:0]  wr_ptr;
    logic [7:0]           rsv_lo;
    logic [LO_W-1:0]      payload;
  } pop_word_t;

  function automatic logic [ADDR_W-1:0] queue_base(input int f);
    return (f == 0) ? 8'h50 : 8'h80;
  endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 96,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  input  logic             ovf_clr,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty,
  output logic             ovf,
  output logic [CNT_W-1:0] count,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] wr_ptr
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      // a dropped commit wins over a clear in the same cycle
      if (push && full)  ovf <= 1'b1;
      else if (ovf_clr)  ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int N = 4,
  parameter logic [N-1:0] APP_MASK = 4'b1001,
  parameter logic [N-1:0] IOP_MASK = 4'b0110
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond,
  input  logic         en_we,
  input  logic [N-1:0] en_din,
  input  logic         ack_we,
  input  logic [N-1:0] ack_din,
  output logic [N-1:0] en,
  output logic [N-1:0] latched,
  output logic         irq_app,
  output logic         irq_iop
);
  logic [N-1:0] ack_mask;

  assign ack_mask = ack_we ? ack_din : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= '0;
      latched <= '0;
    end else begin
      if (en_we) en <= en_din;
      // acknowledge wins for one cycle; a live condition sets the bit again after
      latched <= (latched | cond) & ~ack_mask;
    end
  end

  assign irq_app = |(en & latched & APP_MASK);
  assign irq_iop = |(en & latched & IOP_MASK);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_app,
  output logic              irq_iop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ROOM_MAX = (1 << ST_PTR_W) - 1;

  logic [NFIFO-1:0] hit_ctrl, hit_stage, hit_commit, hit_peek, hit_pop;
  logic [NFIFO-1:0] f_push, f_pop, f_oclr, f_full, f_empty, f_ovf;
  logic [NFIFO-1:0][CNT_W-1:0] f_cnt;
  logic [NFIFO-1:0][PTR_W-1:0] f_rp, f_wp;
  logic [MSG_W-1:0] f_head [NFIFO];
  logic [NIRQ-1:0]  irq_cond, irq_en, irq_lat;
  logic [DATA_W-1:0] rd_next;

  genvar g;
  generate
    for (g = 0; g < NFIFO; g++) begin : g_queue
      localparam logic [ADDR_W-1:0] BASE = queue_base(g);
      logic [HI_W-1:0] stage_q;

      assign hit_ctrl[g]   = (reg_addr == BASE);
      assign hit_stage[g]  = (reg_addr == BASE + OFS_STAGE);
      assign hit_commit[g] = (reg_addr == BASE + OFS_COMMIT);
      assign hit_peek[g]   = (reg_addr == BASE + OFS_PEEK);
      assign hit_pop[g]    = (reg_addr == BASE + OFS_POP);

      assign f_push[g] = reg_wr && hit_commit[g];
      assign f_pop[g]  = reg_rd && hit_pop[g];
      assign f_oclr[g] = reg_wr && hit_ctrl[g] && reg_wdata[BIT_OVF];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     stage_q <= '0;
        else if (reg_wr && hit_stage[g]) stage_q <= reg_wdata[HI_W-1:0];
      end

      mbx_fifo #(.DEPTH(DEPTH), .WIDTH(MSG_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (f_push[g]),
        .push_data ({stage_q, reg_wdata[LO_W-1:0]}),
        .pop       (f_pop[g]),
        .ovf_clr   (f_oclr[g]),
        .head      (f_head[g]),
        .full      (f_full[g]),
        .empty     (f_empty[g]),
        .ovf       (f_ovf[g]),
        .count     (f_cnt[g]),
        .rd_ptr    (f_rp[g]),
        .wr_ptr    (f_wp[g])
      );

      assign irq_cond[2*g]   = f_empty[g];
      assign irq_cond[2*g+1] = !f_empty[g];
    end
  endgenerate

  mbx_irq #(.N(NIRQ)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond    (irq_cond),
    .en_we   (reg_wr && reg_addr == A_IRQ_EN),
    .en_din  (reg_wdata[NIRQ-1:0]),
    .ack_we  (reg_wr && reg_addr == A_IRQ_ACK),
    .ack_din (reg_wdata[NIRQ-1:0]),
    .en      (irq_en),
    .latched (irq_lat),
    .irq_app (irq_app),
    .irq_iop (irq_iop)
  );

  function automatic logic [ST_PTR_W-1:0] room_of(input logic [CNT_W-1:0] c);
    int r;
    r = DEPTH - int'(c);
    return (r > ROOM_MAX) ? ST_PTR_W'(ROOM_MAX) : ST_PTR_W'(r);
  endfunction

  always_comb begin
    pop_word_t pw;
    rd_next = '0;
    pw      = '0;
    if (reg_addr == A_IRQ_EN)  rd_next[NIRQ-1:0] = irq_en;
    if (reg_addr == A_IRQ_ACK) rd_next[NIRQ-1:0] = irq_lat;
    for (int f = 0; f < NFIFO; f++) begin
      if (hit_ctrl[f]) begin
        rd_next[BIT_FULL]  = f_full[f];
        rd_next[BIT_EMPTY] = f_empty[f];
        rd_next[BIT_OVF]   = f_ovf[f];
      end
      if (hit_peek[f] && !f_empty[f]) rd_next = f_head[f][MSG_W-1:LO_W];
      if (hit_pop[f] && !f_empty[f]) begin
        pw.held    = ST_HELD_W'(f_cnt[f]);
        pw.room    = room_of(f_cnt[f]);
        pw.rd_ptr  = ST_PTR_W'(f_rp[f]);
        pw.wr_ptr  = ST_PTR_W'(f_wp[f]);
        pw.payload = f_head[f][LO_W-1:0];
        rd_next    = pw;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic                        reg_wr,
  input logic [NIRQ-1:0]             ack_bits,
  input logic                        reg_rd,
  input logic                        irq_app,
  input logic                        irq_iop,
  input logic [NFIFO-1:0]            full,
  input logic [NFIFO-1:0]            empty,
  input logic [NFIFO-1:0]            ovf,
  input logic [NFIFO-1:0][CNT_W-1:0] cnt,
  input logic [NIRQ-1:0]             lat,
  input logic [NIRQ-1:0]             en
);
  logic ack_wr;
  assign ack_wr = reg_wr && (reg_addr == A_IRQ_ACK);

  genvar g;
  generate
    for (g = 0; g < NFIFO; g++) begin : g_chk
      localparam logic [ADDR_W-1:0] AS = queue_base(g) + OFS_STAGE;
      localparam logic [ADDR_W-1:0] AC = queue_base(g) + OFS_COMMIT;
      localparam logic [ADDR_W-1:0] AP = queue_base(g) + OFS_POP;

      AST_STAGE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AS && !reg_rd) |=> $stable(cnt[g])); // R2
      AST_COMMIT_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AC && !full[g] && !reg_rd) |=> (cnt[g] == CNT_W'($past(cnt[g]) + 1'b1))); // R2
      AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AC && full[g]) |=> ovf[g]); // R5
      AST_EMPTY_POP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == AP && empty[g] && !reg_wr) |=> $stable(cnt[g])); // R6
      AST_EMPTY_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (empty[g] && !(ack_wr && ack_bits[2*g])) |=> lat[2*g]); // R7
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && ack_bits[2*g+1]) |=> !lat[2*g+1]); // R8
    end
  endgenerate

  AST_APP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[0] && !en[3]) |-> !irq_app); // R9
  AST_IOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[1] && !en[2]) |-> !irq_iop); // R9
endmodule

bind ipc_mailbox mbx_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .ack_bits (reg_wdata[3:0]),
  .reg_rd   (reg_rd),
  .irq_app  (irq_app),
  .irq_iop  (irq_iop),
  .full     (f_full),
  .empty    (f_empty),
  .ovf      (f_ovf),
  .cnt      (f_cnt),
  .lat      (irq_lat),
  .en       (irq_en)
);

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [63:0] reg_rdata;
  logic        irq_app, irq_iop;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ipc_mailbox #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .irq_app(irq_app), .irq_iop(irq_iop)
  );

  // behavioural reference model
  logic [95:0] mq0[$];
  logic [95:0] mq1[$];
  logic [63:0] m_stage [2] = '{64'h0, 64'h0};
  logic        m_ovf [2] = '{1'b0, 1'b0};
  int          m_rp [2] = '{0, 0};
  int          m_wp [2] = '{0, 0};
  logic [3:0]  m_en = '0;
  logic [3:0]  m_lat = '0;
  logic [63:0] m_rd = '0;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  function automatic int qsize(input int f);
    return (f == 0) ? mq0.size() : mq1.size();
  endfunction

  function automatic logic [95:0] qhead(input int f);
    return (f == 0) ? mq0[0] : mq1[0];
  endfunction

  always @(posedge clk) begin : model
    logic [3:0] cond, ackm;
    logic [7:0] base;
    int room;
    if (!rst_n) begin
      mq0.delete(); mq1.delete();
      m_stage = '{64'h0, 64'h0}; m_ovf = '{1'b0, 1'b0};
      m_rp = '{0, 0}; m_wp = '{0, 0};
      m_en = '0; m_lat = '0; m_rd = '0;
    end else begin
      cond = {qsize(1) != 0, qsize(1) == 0, qsize(0) != 0, qsize(0) == 0};
      ackm = (reg_wr && reg_addr == 8'h4C) ? reg_wdata[3:0] : 4'h0;
      if (reg_rd) begin
        m_rd = '0;
        if (reg_addr == 8'h48) m_rd[3:0] = m_en;
        if (reg_addr == 8'h4C) m_rd[3:0] = m_lat;
        for (int f = 0; f < 2; f++) begin
          base = (f == 0) ? 8'h50 : 8'h80;
          if (reg_addr == base) begin
            m_rd[16] = (qsize(f) == DEPTH);
            m_rd[17] = (qsize(f) == 0);
            m_rd[18] = m_ovf[f];
          end
          if (reg_addr == base + 8'h20 && qsize(f) != 0) m_rd = qhead(f)[95:32];
          if (reg_addr == base + 8'h28 && qsize(f) != 0) begin
            room = DEPTH - qsize(f);
            if (room > 15) room = 15;
            m_rd = {7'b0, 5'(qsize(f)), 4'(room), 4'(m_rp[f] % 16), 4'(m_wp[f] % 16),
                    8'b0, qhead(f)[31:0]};
            if (f == 0) mq0.delete(0); else mq1.delete(0);
            m_rp[f] = m_rp[f] + 1;
          end
        end
      end
      if (reg_wr) begin
        if (reg_addr == 8'h48) m_en = reg_wdata[3:0];
        for (int f = 0; f < 2; f++) begin
          base = (f == 0) ? 8'h50 : 8'h80;
          if (reg_addr == base && reg_wdata[18]) m_ovf[f] = 1'b0;
          if (reg_addr == base + 8'h10) m_stage[f] = reg_wdata;
          if (reg_addr == base + 8'h18) begin
            if (qsize(f) == DEPTH) m_ovf[f] = 1'b1;
            else begin
              if (f == 0) mq0.push_back({m_stage[f], reg_wdata[31:0]});
              else        mq1.push_back({m_stage[f], reg_wdata[31:0]});
              m_wp[f] = m_wp[f] + 1;
            end
          end
        end
      end
      m_lat = (m_lat | cond) & ~ackm;
    end
  end

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
    end
  endtask

  // compare every cycle, half a period after the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("reg_rdata", reg_rdata, m_rd);
      chk("irq_app", 64'(irq_app), 64'(|(m_en & m_lat & 4'b1001)));
      chk("irq_iop", 64'(irq_iop), 64'(|(m_en & m_lat & 4'b0110)));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; reg_rd = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1; reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      reg_wr = 1'b0; reg_rd = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL %s watchdog: got timeout expected completion", cur_req);
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R1"; // reset state of control, enable and status words
    rd(8'h50); rd(8'h80); rd(8'h48); rd(8'h4C); idle(2);

    cur_req = "R2"; // staging write alone does not commit
    wr(8'h60, 64'h1111_2222_3333_4444); rd(8'h50);
    wr(8'h68, 64'hFFFF_FFFF_AAAA_0001); rd(8'h50);
    wr(8'h60, 64'h5555_6666_7777_8888); wr(8'h68, 64'h0000_0000_AAAA_0002);
    wr(8'h60, 64'h9999_AAAA_BBBB_CCCC); wr(8'h68, 64'h0000_0000_AAAA_0003);

    cur_req = "R3"; // peek leaves the head in place
    rd(8'h70); rd(8'h70); idle(1);

    cur_req = "R4"; // pop word fields and ordering
    rd(8'h78); rd(8'h70); rd(8'h78); rd(8'h78); rd(8'h50); idle(1);

    cur_req = "R6"; // empty reads
    rd(8'h78); rd(8'h70); rd(8'hA8); rd(8'hA0); rd(8'h50); idle(1);

    cur_req = "R5"; // fill past capacity, drop, sticky flag, clear
    for (int i = 0; i < 17; i++) begin
      wr(8'h90, {32'hC0DE_0000 + 32'(i), 32'h0});
      wr(8'h98, 64'(32'hB000_0000 + 32'(i)));
    end
    rd(8'h80); rd(8'h50);
    for (int i = 0; i < 16; i++) rd(8'hA8);
    rd(8'h80);
    wr(8'h80, 64'h4_0000); rd(8'h80); idle(1);

    cur_req = "R10"; // queues independent; read data held
    wr(8'h90, 64'hDEAD_BEEF_0000_0001); wr(8'h98, 64'h1234_5678);
    rd(8'h50); idle(3); rd(8'hA0); idle(2);

    cur_req = "R9"; // enable routing to the two lines
    wr(8'h48, 64'h6); idle(2); rd(8'h48);
    wr(8'h48, 64'h9); idle(2);

    cur_req = "R8"; // acknowledge clears; live condition returns
    wr(8'h4C, 64'hF); idle(1); rd(8'h4C); idle(2); rd(8'h4C);
    wr(8'h4C, 64'h1); idle(3);

    cur_req = "R7"; // history kept until acknowledged
    rd(8'hA8); idle(2); rd(8'h4C);
    wr(8'h60, 64'h1); wr(8'h68, 64'h2); idle(1); rd(8'h78); idle(2); rd(8'h4C);
    wr(8'h48, 64'hF); idle(2);
    wr(8'h4C, 64'h2); idle(2); rd(8'h4C); idle(3);

    finish_run();
  end
endmodule